// File: doc/BRIEF.md
# Branch Trace Buffer

This block keeps a short history of program-flow discontinuities. Each time the core takes a branch it presents the branch origin and the branch target as one event. If the event passes the qualification rules, the block stores it as a record of two 32-bit words in a circular store of 16 entries. A control word chooses two things. It sets what happens when the store is full: the oldest record is discarded, or the event is refused and an exception is raised. It also sets whether repeated branch pairs are folded into records already held, which keeps tight software loops from flooding the history.

Software reaches the block through a 32-bit register port with three registers: a control register, a status register that gives the record count, and a pop register for reading records. Readback is newest-first. Each record takes two reads, target word first and origin word second, and the record leaves the store on the second read. A read that pops and a branch event in the same cycle are handled as pop first, then event.

Top module: `flow_trace_buffer`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, a read of the pop register returns 0 and `ovfExc` is low.
- R2: Only the control register, at offset 0x000, is writable. Bits [4:0] are kept and the upper bits read 0. Bit 0 is power, bit 1 is enable, bit 2 is exception-on-full, bit 3 is single-repeat folding and bit 4 is double-repeat folding. Writes to the status register (0x004) and to the pop register (0x100) change nothing. An access whose `regBe` is not 4'hF is ignored: it writes nothing, reads 0 and pops nothing.
- R3: An event is stored only while both power and enable are set.
- R4: Events with `evLoop` high are never stored. Events at level 1 (reset level) are never stored. While exception-on-full is set, events at levels 0 to 3 are dropped.
- R5: When the store holds 16 records and exception-on-full is set, a qualifying event is dropped and `ovfExc` is high for one cycle, in the cycle after the event.
- R6: When the store holds 16 records and exception-on-full is clear, a qualifying event first discards the oldest record. It is then folded or stored as normal, so an event that gets folded still leaves 15 records.
- R7: With single-repeat folding on and at least one record held, an event whose origin and target equal those of the newest record in bits [31:1] is not stored. Bit 0 of that record's target is set instead.
- R8: With double-repeat folding on, at least two records held, and no single-repeat match, an event that matches the second-newest record in bits [31:1] is not stored. Bit 0 of that record's origin is set instead.
- R9: Reads of offset 0x100 return the newest record's target word, then its origin word. The record is removed on the origin read.
- R10: A pop-register read with no records held returns 0 and leaves the target/origin phase unchanged.
- R11: The status register (0x004) returns the number of records held, capped at 16.
- R12: When a popping read and a qualifying event fall in the same cycle, the pop is applied first and the event is then judged against the remaining records.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evValid | input | 1 | Branch event present this cycle |
| evSrc | input | 32 | Branch origin address |
| evDst | input | 32 | Branch target address |
| evLoop | input | 1 | Event comes from a hardware loop |
| evLevel | input | 4 | Core's current interrupt level |
| ovfExc | output | 1 | Overflow exception pulse |
| regAddr | input | 9 | Register byte offset |
| regBe | input | 4 | Byte enables; only 4'hF is accepted |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the cycle of `regRd` |

## Verification
The bound checker runs on every cycle. It checks that the record count never goes above 16 and that the count grows only after an event seen with power and enable set. It also checks that the count shrinks only after a pop read or an overwrite of a full store, that `ovfExc` follows only an event that met a full store with exception-on-full set, and that an empty pop read returns 0. The bench scenarios are needed to show the folding rules, the newest-first word order, the discard of the oldest record, the level filtering and the pop-then-push ordering, because these depend on record contents and on sequences of events.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int AW = 32;

  // control bit positions (software-visible)
  localparam int CTL_PWR  = 0;
  localparam int CTL_EN   = 1;
  localparam int CTL_OVX  = 2;
  localparam int CTL_CMP1 = 3;
  localparam int CTL_CMP2 = 4;
  localparam int CTL_W    = 5;

  localparam logic [8:0] OFS_CTL  = 9'h000;
  localparam logic [8:0] OFS_STAT = 9'h004;
  localparam logic [8:0] OFS_DATA = 9'h100;

  localparam logic [3:0] LVL_RESET   = 4'd1;
  localparam logic [3:0] LVL_EXC_MAX = 4'd3;

  typedef struct packed {
    logic pop;
    logic push;
    logic markDst;
    logic markSrc;
    logic dropOldest;
  } trace_strobe_t;
endpackage

// File: rtl/trace_store.sv
module trace_store
  import trace_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  trace_strobe_t stb,
  input  logic [AW-1:0] evSrc,
  input  logic [AW-1:0] evDst,
  output logic [CW-1:0] recCount,
  output logic [AW-1:0] new1Src,
  output logic [AW-1:0] new1Dst,
  output logic [AW-1:0] new2Src,
  output logic [AW-1:0] new2Dst,
  output logic [AW-1:0] new3Src,
  output logic [AW-1:0] new3Dst
);
  localparam logic [IW-1:0] ONE   = IW'(1);
  localparam logic [IW-1:0] TWO   = IW'(2);
  localparam logic [IW-1:0] THREE = IW'(3);

  logic [IW-1:0] topPtr;
  logic [AW-1:0] srcMem [DEPTH];
  logic [AW-1:0] dstMem [DEPTH];

  logic [IW-1:0] effTop, effNew1, effNew2;
  assign effTop  = stb.pop ? topPtr - ONE : topPtr;
  assign effNew1 = effTop - ONE;
  assign effNew2 = effTop - TWO;

  // views relative to the current top; control picks per pop
  assign new1Src = srcMem[topPtr - ONE];
  assign new1Dst = dstMem[topPtr - ONE];
  assign new2Src = srcMem[topPtr - TWO];
  assign new2Dst = dstMem[topPtr - TWO];
  assign new3Src = srcMem[topPtr - THREE];
  assign new3Dst = dstMem[topPtr - THREE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      topPtr   <= '0;
      recCount <= '0;
    end else begin
      topPtr   <= stb.push ? effTop + ONE : effTop;
      recCount <= recCount - CW'(stb.pop) - CW'(stb.dropOldest) + CW'(stb.push);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        srcMem[i] <= '0;
        dstMem[i] <= '0;
      end
    end else begin
      if (stb.push) begin
        srcMem[effTop] <= evSrc;
        dstMem[effTop] <= evDst;
      end
      if (stb.markDst) dstMem[effNew1][0] <= 1'b1;
      if (stb.markSrc) srcMem[effNew2][0] <= 1'b1;
    end
  end
endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int STAT_CAP = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evValid,
  input  logic [AW-1:0]    evSrc,
  input  logic [AW-1:0]    evDst,
  input  logic             evLoop,
  input  logic [3:0]       evLevel,
  input  logic [8:0]       regAddr,
  input  logic [3:0]       regBe,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  output logic             ovfExc,
  output logic [CTL_W-1:0] ctrlBits,
  input  logic [CW-1:0]    recCount,
  input  logic [AW-1:0]    new1Src,
  input  logic [AW-1:0]    new1Dst,
  input  logic [AW-1:0]    new2Src,
  input  logic [AW-1:0]    new2Dst,
  input  logic [AW-1:0]    new3Src,
  input  logic [AW-1:0]    new3Dst,
  output trace_strobe_t    stb
);
  function automatic logic sameIgnLsb(logic [AW-1:0] a, logic [AW-1:0] b);
    return a[AW-1:1] == b[AW-1:1];
  endfunction

  logic [CTL_W-1:0] ctrlQ;
  logic             halfQ;
  assign ctrlBits = ctrlQ;

  logic accOk, rdData, haveRec;
  assign accOk   = (regBe == 4'hF);
  assign rdData  = regRd && accOk && (regAddr == OFS_DATA);
  assign haveRec = (recCount != '0);

  logic popNow;
  assign popNow = rdData && haveRec && halfQ;

  // state as seen by the event after the pop
  logic [CW-1:0] effCount;
  logic [AW-1:0] topSrc, topDst, prvSrc, prvDst;
  assign effCount = recCount - CW'(popNow);
  assign topSrc   = popNow ? new2Src : new1Src;
  assign topDst   = popNow ? new2Dst : new1Dst;
  assign prvSrc   = popNow ? new3Src : new2Src;
  assign prvDst   = popNow ? new3Dst : new2Dst;

  logic qualify, full, excHit, hit1, hit2, keep;
  assign qualify = evValid && ctrlQ[CTL_PWR] && ctrlQ[CTL_EN] && !evLoop
                && (evLevel != LVL_RESET)
                && !(ctrlQ[CTL_OVX] && (evLevel <= LVL_EXC_MAX));
  assign full   = (effCount == CW'(DEPTH));
  assign excHit = qualify && full && ctrlQ[CTL_OVX];
  assign keep   = qualify && !excHit;
  assign hit1   = ctrlQ[CTL_CMP1] && (effCount != '0)
               && sameIgnLsb(evSrc, topSrc) && sameIgnLsb(evDst, topDst);
  assign hit2   = ctrlQ[CTL_CMP2] && (effCount >= CW'(2))
               && sameIgnLsb(evSrc, prvSrc) && sameIgnLsb(evDst, prvDst);

  always_comb begin
    stb            = '0;
    stb.pop        = popNow;
    stb.dropOldest = keep && full;
    stb.markDst    = keep && hit1;
    stb.markSrc    = keep && !hit1 && hit2;
    stb.push       = keep && !hit1 && !hit2;
  end

  logic [31:0] countWide, statVal;
  assign countWide = 32'(recCount);
  assign statVal   = (countWide > 32'(STAT_CAP)) ? 32'(STAT_CAP) : countWide;

  always_comb begin
    regRdata = '0;
    if (regRd && accOk) begin
      unique case (regAddr)
        OFS_CTL:  regRdata = 32'(ctrlQ);
        OFS_STAT: regRdata = statVal;
        OFS_DATA: regRdata = !haveRec ? '0 : (halfQ ? new1Src : new1Dst);
        default:  regRdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlQ  <= '0;
      halfQ  <= 1'b0;
      ovfExc <= 1'b0;
    end else begin
      ovfExc <= excHit;
      if (rdData && haveRec) halfQ <= !halfQ;
      if (regWr && accOk && (regAddr == OFS_CTL)) ctrlQ <= regWdata[CTL_W-1:0];
    end
  end
endmodule

// File: rtl/flow_trace_buffer.sv
module flow_trace_buffer
  import trace_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int STAT_CAP = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evValid,
  input  logic [31:0] evSrc,
  input  logic [31:0] evDst,
  input  logic        evLoop,
  input  logic [3:0]  evLevel,
  output logic        ovfExc,
  input  logic [8:0]  regAddr,
  input  logic [3:0]  regBe,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata
);
  localparam int CW = $clog2(DEPTH + 1);

  trace_strobe_t    stb;
  logic [CW-1:0]    recCount;
  logic [CTL_W-1:0] ctrlBits;
  logic [AW-1:0]    n1s, n1d, n2s, n2d, n3s, n3d;

  trace_ctrl #(.DEPTH(DEPTH), .STAT_CAP(STAT_CAP)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .evValid(evValid), .evSrc(evSrc), .evDst(evDst), .evLoop(evLoop), .evLevel(evLevel),
    .regAddr(regAddr), .regBe(regBe), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata),
    .ovfExc(ovfExc), .ctrlBits(ctrlBits), .recCount(recCount),
    .new1Src(n1s), .new1Dst(n1d), .new2Src(n2s), .new2Dst(n2d),
    .new3Src(n3s), .new3Dst(n3d), .stb(stb)
  );

  trace_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .stb(stb), .evSrc(evSrc), .evDst(evDst),
    .recCount(recCount),
    .new1Src(n1s), .new1Dst(n1d), .new2Src(n2s), .new2Dst(n2d),
    .new3Src(n3s), .new3Dst(n3d)
  );
endmodule

// File: rtl/trace_checker.sv
module trace_checker #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          evValid,
  input logic          ovfExc,
  input logic [8:0]    regAddr,
  input logic [3:0]    regBe,
  input logic          regRd,
  input logic [31:0]   regRdata,
  input logic [4:0]    ctrlBits,
  input logic [CW-1:0] recCount
);
  logic dataRd;
  assign dataRd = regRd && (regBe == 4'hF) && (regAddr == 9'h100);

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    recCount <= CW'(DEPTH));

  assert_grow_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (recCount > $past(recCount)) |-> $past(evValid && ctrlBits[0] && ctrlBits[1]));

  assert_exc_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovfExc |-> ($past(recCount) == CW'(DEPTH) && $past(ctrlBits[2]) && $past(evValid)));

  assert_empty_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dataRd && recCount == '0) |-> (regRdata == 32'd0));

  // R6 folding on a full store also shrinks the count
  assert_shrink_needs_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (recCount < $past(recCount)) |-> ($past(dataRd) || $past(recCount) == CW'(DEPTH)));
endmodule

bind flow_trace_buffer trace_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .evValid(evValid), .ovfExc(ovfExc),
  .regAddr(regAddr), .regBe(regBe), .regRd(regRd), .regRdata(regRdata),
  .ctrlBits(ctrlBits), .recCount(recCount)
);

// File: tb/tb_flow_trace_buffer.sv
`timescale 1ns/1ps
module tb_flow_trace_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evValid = 1'b0, evLoop = 1'b0;
  logic [31:0] evSrc = '0, evDst = '0;
  logic [3:0]  evLevel = '0;
  logic        ovfExc;
  logic [8:0]  regAddr = '0;
  logic [3:0]  regBe = '0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;

  always #4 clk = ~clk;

  flow_trace_buffer dut (.*);

  int total = 0, bad = 0;

  // reference model: index 0 oldest
  logic [31:0] mSrc [16];
  logic [31:0] mDst [16];
  int   mCount = 0;
  bit   mHalf = 0;
  bit [4:0] mCtl = 0;
  bit   expExc = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(logic [8:0] a, logic [3:0] be);
    if (be != 4'hF) return 0;
    case (a)
      9'h000: return 32'(mCtl);
      9'h004: return (mCount > 16) ? 32'd16 : 32'(mCount);
      9'h100: return (mCount == 0) ? 32'd0 : (mHalf ? mSrc[mCount-1] : mDst[mCount-1]);
      default: return 0;
    endcase
  endfunction

  function automatic bit same(logic [31:0] a, logic [31:0] b);
    return a[31:1] == b[31:1];
  endfunction

  function automatic void modelStep(bit rd, logic [8:0] a, logic [3:0] be, bit wr,
                                    logic [31:0] wd, bit ev, logic [31:0] s,
                                    logic [31:0] d, bit lp, logic [3:0] lv);
    bit q;
    int n;
    expExc = 0;
    if (rd && be == 4'hF && a == 9'h100 && mCount > 0) begin
      if (mHalf) mCount--;
      mHalf = !mHalf;
    end
    q = ev && mCtl[0] && mCtl[1] && !lp && lv != 4'd1 && !(mCtl[2] && lv <= 4'd3);
    if (q) begin
      n = mCount;
      if (n == 16) begin
        if (mCtl[2]) begin expExc = 1; q = 0; end
        else begin
          for (int i = 0; i < 15; i++) begin mSrc[i] = mSrc[i+1]; mDst[i] = mDst[i+1]; end
          mCount = 15;
        end
      end
      if (q) begin
        if (mCtl[3] && n >= 1 && same(s, mSrc[mCount-1]) && same(d, mDst[mCount-1]))
          mDst[mCount-1][0] = 1'b1;
        else if (mCtl[4] && n >= 2 && same(s, mSrc[mCount-2]) && same(d, mDst[mCount-2]))
          mSrc[mCount-2][0] = 1'b1;
        else begin
          mSrc[mCount] = s; mDst[mCount] = d; mCount++;
        end
      end
    end
    if (wr && be == 4'hF && a == 9'h000) mCtl = wd[4:0];
  endfunction

  task automatic doCycle(string tag, bit rd, logic [8:0] a, logic [3:0] be, bit wr,
                         logic [31:0] wd, bit ev, logic [31:0] s, logic [31:0] d,
                         bit lp, logic [3:0] lv);
    logic [31:0] e;
    @(negedge clk);
    chk(ovfExc === expExc, "R5 ovfExc", 32'(ovfExc), 32'(expExc));
    regRd = rd; regAddr = a; regBe = be; regWr = wr; regWdata = wd;
    evValid = ev; evSrc = s; evDst = d; evLoop = lp; evLevel = lv;
    #1;
    if (rd) begin
      e = expRead(a, be);
      chk(regRdata === e, tag, regRdata, e);
    end
    modelStep(rd, a, be, wr, wd, ev, s, d, lp, lv);
  endtask

  task automatic wrCtl(logic [31:0] v);
    doCycle("R2", 0, 9'h000, 4'hF, 1, v, 0, 0, 0, 0, 0);
  endtask
  task automatic rdReg(logic [8:0] a, string tag);
    doCycle(tag, 1, a, 4'hF, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic evt(logic [31:0] s, logic [31:0] d, bit lp, logic [3:0] lv);
    doCycle("R3", 0, 0, 0, 0, 0, 1, s, d, lp, lv);
  endtask

  initial begin
    #(8ns * 200000);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) begin mSrc[i] = 0; mDst[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(ovfExc === 1'b0, "R1 ovfExc", 32'(ovfExc), 0);
    rdReg(9'h000, "R1 ctrl");
    rdReg(9'h004, "R1 status");
    rdReg(9'h100, "R1 data");
    // R2 register access rules
    wrCtl(32'hFFFF_FFFF);
    rdReg(9'h000, "R2 ctrl mask");
    doCycle("R2", 0, 9'h000, 4'h3, 1, 32'h0, 0, 0, 0, 0, 0);
    rdReg(9'h000, "R2 partial write ignored");
    // R3 power/enable
    wrCtl(32'h1); evt(32'h100, 32'h200, 0, 4'd6); rdReg(9'h004, "R3 power only");
    wrCtl(32'h2); evt(32'h100, 32'h200, 0, 4'd6); rdReg(9'h004, "R3 enable only");
    // R4 filtering
    wrCtl(32'h3);
    evt(32'h100, 32'h200, 1, 4'd6); evt(32'h100, 32'h200, 0, 4'd1);
    rdReg(9'h004, "R4 loop/reset level");
    wrCtl(32'h7); evt(32'h100, 32'h200, 0, 4'd2);
    rdReg(9'h004, "R4 low level with ovx");
    evt(32'h104, 32'h208, 0, 4'd4);
    rdReg(9'h004, "R4 level 4 stored");
    doCycle("R2", 0, 9'h004, 4'hF, 1, 32'h55, 0, 0, 0, 0, 0);
    doCycle("R2", 0, 9'h100, 4'hF, 1, 32'h77, 0, 0, 0, 0, 0);
    rdReg(9'h004, "R2 status write ignored");
    doCycle("R2 partial read", 1, 9'h100, 4'h1, 0, 0, 0, 0, 0, 0, 0);
    // R9 / R10 readback
    rdReg(9'h100, "R9 dst word"); rdReg(9'h100, "R9 src word");
    rdReg(9'h004, "R9 popped");
    rdReg(9'h100, "R10 empty"); rdReg(9'h100, "R10 empty again");
    wrCtl(32'h3); evt(32'h300, 32'h400, 0, 4'd9);
    rdReg(9'h100, "R10 phase kept"); rdReg(9'h100, "R9 src");
    // R7 single-repeat folding
    wrCtl(32'h0B);
    evt(32'h500, 32'h600, 0, 4'd9); evt(32'h501, 32'h600, 0, 4'd9);
    rdReg(9'h004, "R7 count"); rdReg(9'h100, "R7 dst lsb"); rdReg(9'h100, "R7 src");
    wrCtl(32'h3);
    evt(32'h500, 32'h600, 0, 4'd9); evt(32'h500, 32'h600, 0, 4'd9);
    rdReg(9'h004, "R7 off stores both");
    rdReg(9'h100, "R7"); rdReg(9'h100, "R7"); rdReg(9'h100, "R7"); rdReg(9'h100, "R7");
    // R8 double-repeat folding
    wrCtl(32'h13);
    evt(32'hA00, 32'hB00, 0, 4'd9); evt(32'hC00, 32'hD00, 0, 4'd9); evt(32'hA00, 32'hB01, 0, 4'd9);
    rdReg(9'h004, "R8 count");
    for (int i = 0; i < 4; i++) rdReg(9'h100, "R8 words");
    // R6 overwrite oldest
    wrCtl(32'h3);
    for (int i = 0; i < 18; i++) evt(32'h1000 + 32'(i) * 16, 32'h2000 + 32'(i) * 16, 0, 4'd8);
    rdReg(9'h004, "R6 full count");
    for (int i = 0; i < 32; i++) rdReg(9'h100, "R6 lifo after wrap");
    // R6 folding on full still drops oldest
    wrCtl(32'hB);
    for (int i = 0; i < 16; i++) evt(32'h3000 + 32'(i) * 16, 32'h4000, 0, 4'd8);
    evt(32'h30F0, 32'h4000, 0, 4'd8);
    rdReg(9'h004, "R6 fold on full");
    for (int i = 0; i < 30; i++) rdReg(9'h100, "R6 drain");
    // R5 exception on full
    wrCtl(32'h7);
    for (int i = 0; i < 17; i++) evt(32'h5000 + 32'(i) * 16, 32'h6000, 0, 4'd8);
    rdReg(9'h004, "R5 count held");
    // R12 pop then push
    wrCtl(32'h3);
    rdReg(9'h100, "R12 dst");
    doCycle("R12 pop with event", 1, 9'h100, 4'hF, 0, 0, 1, 32'h7770, 32'h8880, 0, 4'd8);
    rdReg(9'h004, "R12 count"); rdReg(9'h100, "R12 new dst");
    // random phase
    for (int k = 0; k < 3000; k++) begin
      bit rd, wr, ev, lp;
      logic [8:0] a;
      logic [3:0] be, lv;
      logic [31:0] wd, s, d;
      int r;
      wr = ($urandom % 100) < 4;
      wd = {$urandom} & 32'h1F;
      if (($urandom % 4) != 0) wd[1:0] = 2'b11;
      rd = !wr && (($urandom % 100) < 45);
      r = $urandom % 6;
      a = (r == 0) ? 9'h000 : (r == 1) ? 9'h004 : (r == 5) ? 9'h008 : 9'h100;
      be = (($urandom % 10) == 0) ? 4'h7 : 4'hF;
      ev = ($urandom % 100) < 60;
      s = 32'h1000 + 32'($urandom % 4) * 4 + 32'($urandom % 2);
      d = 32'h2000 + 32'($urandom % 3) * 4 + 32'($urandom % 2);
      lp = ($urandom % 10) == 0;
      lv = (($urandom % 4) == 0) ? 4'($urandom % 4) : 4'(4 + $urandom % 12);
      doCycle("R9 random", rd, a, be, wr, wd, ev, s, d, lp, lv);
    end
    doCycle("R11 final status", 1, 9'h004, 4'hF, 0, 0, 0, 0, 0, 0, 0);
    doCycle("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule